// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is a serial chain of boundary-scan cells placed around the primary inputs and primary outputs of a core-logic block. Every input pin has a cell between the pin and the core. Every core output has a cell between the core and the output pin. The cells are linked into a single shift path. The path runs from `tdi_i` to `tdo_o` and is timed by the test clock `tck_i`.

Three strobes control the chain: capture, shift and update. They come from an external test controller, which is not part of this block. On a capture, each input cell samples its pin and each output cell samples the value the core drives. The captured values can then be shifted out serially, while new values are shifted in at the same time. An update copies the shifted-in values into a second stage of holding latches. With `test_mode_i` high, those latches drive the core inputs and the device output pins. With `test_mode_i` low, every cell is transparent and the device works normally. `tdo_o` changes only on the falling edge of the test clock, so several devices can be cascaded TDO-to-TDI on a shared clock.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_ni` is low, every capture/shift stage, every update latch and `tdo_o` are 0. So with `test_mode_i` high, `core_in_o`, `pin_out_o` and `tdo_o` all read 0.
- R2: With `test_mode_i` low, `core_in_o` equals `pin_in_i` and `pin_out_o` equals `core_out_i` combinationally, whatever the cells hold.
- R3: On a rising `tck_i` edge with `capture_i` high, input cell k loads `pin_in_i[k]` and output cell k loads `core_out_i[k]`. Capture takes priority over `shift_i`.
- R4: Chain position 0 is next to `tdi_i`. Input cells occupy positions 0..N_IN-1 and output cells occupy positions N_IN..N_IN+N_OUT-1. On a rising edge with `shift_i` high and `capture_i` low, position 0 loads `tdi_i` and position j loads position j-1.
- R5: On every falling `tck_i` edge, `tdo_o` loads the stage of the last position. After a capture, the bits leave in the order output cell N_OUT-1 down to output cell 0, then input cell N_IN-1 down to input cell 0.
- R6: On a falling edge with `update_i` high, each update latch loads its cell's stage. With `test_mode_i` high, the input-cell latches drive `core_in_o` and the output-cell latches drive `pin_out_o`.
- R7: Without `update_i`, the update latches and therefore the test-mode outputs stay unchanged during capture and shift.
- R8: With `capture_i` and `shift_i` both low, the stages hold, and `tdo_o` stays constant whatever `tdi_i` does.
- R9: With shift held high, the bit driven on `tdi_i` before shift edge k appears on `tdo_o` before shift edge k+N_IN+N_OUT. This is what lets devices be cascaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tdi_i | input | 1 | Serial test data into position 0 |
| capture_i | input | 1 | Parallel capture strobe (rising edge) |
| shift_i | input | 1 | Serial shift strobe (rising edge) |
| update_i | input | 1 | Update strobe (falling edge) |
| test_mode_i | input | 1 | 1: latches drive outputs; 0: transparent |
| pin_in_i | input | N_IN | Device input pins |
| core_in_o | output | N_IN | Signals into the core |
| core_out_i | input | N_OUT | Signals from the core |
| pin_out_o | output | N_OUT | Device output pins |
| tdo_o | output | 1 | Serial test data out, changes on falling edge |

## Verification
Capture and shift results live in the stages from the rising edge they occur on, but they are only visible one half-period later, when `tdo_o` loads on the following falling edge. The bench therefore samples `tdo_o` 1 ns after each falling edge, before the next shift edge. Update results reach `core_in_o` and `pin_out_o` at the falling edge where `update_i` is high, and the bench reads them 1 ns after the rising edge that follows. Transparent-mode outputs are combinational and are compared 1 ns after the inputs change, with no clock involved.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic {
    CELL_IN  = 1'b0,
    CELL_OUT = 1'b1
  } cell_kind_e;

  // input cells sit nearest tdi, output cells nearest tdo
  function automatic cell_kind_e kind_of(input int pos, input int n_in);
    return (pos < n_in) ? CELL_IN : CELL_OUT;
  endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic test_mode_i,
  input  logic si_i,
  input  logic pi_i,
  output logic so_o,
  output logic po_o
);

  logic stage_q;
  logic upd_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        stage_q <= 1'b0;
    else if (capture_i) stage_q <= pi_i;
    else if (shift_i)   stage_q <= si_i;
  end

  // second stage keeps parallel output steady while shifting
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       upd_q <= 1'b0;
    else if (update_i) upd_q <= stage_q;
  end

  assign so_o = stage_q;
  assign po_o = test_mode_i ? upd_q : pi_i;

  p_capture_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> stage_q == $past(pi_i));

  p_shift_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> stage_q == $past(si_i));

  p_hold_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!shift_i && !capture_i) |=> $stable(stage_q));

  p_upd_load_r6: assert property (@(negedge tck_i) disable iff (!rst_ni)
    update_i |=> upd_q == $past(stage_q));

  p_upd_hold_r7: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(upd_q));

endmodule

// File: rtl/bscan_tdo_reg.sv
module bscan_tdo_reg (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end

  p_tdo_r5: assert property (@(negedge tck_i) disable iff (!rst_ni)
    rst_ni |=> q_o == $past(d_i));

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tdi_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic             test_mode_i,
  input  logic [N_IN-1:0]  pin_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_OUT-1:0] core_out_i,
  output logic [N_OUT-1:0] pin_out_o,
  output logic             tdo_o
);

  import bscan_pkg::*;

  localparam int LEN = N_IN + N_OUT;

  logic [LEN-1:0] so_w;
  logic [LEN-1:0] si_w;
  logic [LEN-1:0] pi_w;
  logic [LEN-1:0] po_w;

  assign si_w = {so_w[LEN-2:0], tdi_i};

  for (genvar p = 0; p < LEN; p++) begin : g_cell
    if (kind_of(p, N_IN) == CELL_IN) begin : g_in
      assign pi_w[p]      = pin_in_i[p];
      assign core_in_o[p] = po_w[p];
    end else begin : g_out
      assign pi_w[p]           = core_out_i[p-N_IN];
      assign pin_out_o[p-N_IN] = po_w[p];
    end

    bscan_cell u_cell (
      .tck_i       (tck_i),
      .rst_ni      (rst_ni),
      .capture_i   (capture_i),
      .shift_i     (shift_i),
      .update_i    (update_i),
      .test_mode_i (test_mode_i),
      .si_i        (si_w[p]),
      .pi_i        (pi_w[p]),
      .so_o        (so_w[p]),
      .po_o        (po_w[p])
    );
  end

  bscan_tdo_reg u_tdo (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .d_i    (so_w[LEN-1]),
    .q_o    (tdo_o)
  );

  p_tdo_idle_r8: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (!$past(shift_i) && !$past(capture_i) && !shift_i && !capture_i) |=> $stable(tdo_o));

endmodule

// File: tb/bscan_chain_test.sv
`timescale 1ns/1ps
module bscan_chain_test;

  localparam int NI = 3;
  localparam int NO = 2;
  localparam int L  = NI + NO;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tdi = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tmode = 1'b1;
  logic [NI-1:0] pin_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = '0;
  logic [NO-1:0] pin_out;
  logic tdo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 tck = ~tck;

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) uut (
    .tck_i(tck), .rst_ni(rst_n), .tdi_i(tdi), .capture_i(cap), .shift_i(sh),
    .update_i(upd), .test_mode_i(tmode), .pin_in_i(pin_in), .core_in_o(core_in),
    .core_out_i(core_out), .pin_out_o(pin_out), .tdo_o(tdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic post_pos();
    @(posedge tck); #1;
  endtask

  task automatic post_neg();
    @(negedge tck); #1;
  endtask

  initial begin
    logic [L-1:0] prev_p = '0;
    logic [2*L-1:0] stream;
    // R1: reset state, test mode selects zeroed latches
    #3;
    chk("R1 core_in", 32'(core_in), 0);
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 tdo", 32'(tdo), 0);
    post_pos();
    rst_n = 1'b1;
    post_pos();

    // R2: transparent sweep, purely combinational
    tmode = 1'b0;
    for (int v = 0; v < (1 << L); v++) begin
      {core_out, pin_in} = L'(v);
      #1;
      chk("R2 core_in", 32'(core_in), 32'(v % (1 << NI)));
      chk("R2 pin_out", 32'(pin_out), 32'(v >> NI));
    end
    tmode = 1'b1;
    post_pos();

    for (int v = 0; v < (1 << L); v++) begin
      logic [L-1:0] capv = L'(v);
      logic [L-1:0] pv   = L'(v * 7 + 3);
      {core_out, pin_in} = capv;
      cap = 1'b1;
      sh  = capv[0];  // R3: capture wins over shift
      post_pos();
      cap = 1'b0;
      sh  = 1'b1;
      {core_out, pin_in} = ~capv;
      for (int k = 0; k < L; k++) begin
        post_neg();
        chk("R3/R4/R5 tdo bit", 32'(tdo), 32'(capv[L-1-k]));
        chk("R7 core_in", 32'(core_in), 32'(prev_p[NI-1:0]));
        chk("R7 pin_out", 32'(pin_out), 32'(prev_p[L-1:NI]));
        tdi = pv[L-1-k];
        post_pos();
      end
      sh  = 1'b0;
      upd = 1'b1;
      post_pos();
      upd = 1'b0;
      chk("R6 core_in", 32'(core_in), 32'(pv[NI-1:0]));
      chk("R6 pin_out", 32'(pin_out), 32'(pv[L-1:NI]));
      chk("R5 tdo after shift-in", 32'(tdo), 32'(pv[L-1]));
      // R8: idle with tdi toggling
      for (int k = 0; k < 2; k++) begin
        tdi = ~tdi;
        post_pos();
        chk("R8 tdo idle", 32'(tdo), 32'(pv[L-1]));
      end
      prev_p = pv;
    end

    // R9: stream passes through after exactly L shift edges
    stream = (2*L)'(32'h2d3 ^ 32'h155);
    sh = 1'b1;
    for (int k = 0; k < 2*L; k++) begin
      post_neg();
      if (k >= L) chk("R9 delay", 32'(tdo), 32'(stream[k-L]));
      else        chk("R9 prefill", 32'(tdo), 32'(prev_p[L-1-k]));
      tdi = stream[k];
      post_pos();
    end
    sh = 1'b0;
    chk("R7 after stream core_in", 32'(core_in), 32'(prev_p[NI-1:0]));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule